// File: doc/BRIEF.md
# Windowed Watchdog with Write-Once Control

This block is a watchdog timer for a processor subsystem. Software configures it through an 8-bit control register. The control register sets the timeout rate, enables windowed servicing and lets the counter freeze while the chip is halted for debug. A single-cycle register-bus write with a one-bit address reaches either the control register or a service register. Software keeps the watchdog quiet by writing an arm key (0x55) and then a fire key (0xAA) to the service register. When servicing is late, early or wrong, the block raises a one-cycle reset request for the chip's reset sequencer.

The control register is protected. An input selects between normal and special mode. In normal mode, the window and rate fields accept only one write. A second write is ignored even when the first one wrote zeros. The debug-stop bit can be set but never cleared. In special mode, all fields may be written at any time. A key-sequence controller with three named states, SEQ_IDLE, SEQ_ARMED and SEQ_TRIP, checks the service writes against a free-running period counter.

The controller uses these transitions:
- SEQ_IDLE to SEQ_ARMED: a 0x55 write.
- SEQ_ARMED to SEQ_ARMED: a repeated 0x55 write.
- SEQ_ARMED to SEQ_IDLE: a 0xAA write. This is the kick, and it restarts the period.
- SEQ_IDLE or SEQ_ARMED to SEQ_TRIP: any bad write, an early write in window mode, or the end of the period without a kick.
- SEQ_TRIP to SEQ_IDLE: always, after one cycle.

Top module: `win_watchdog`

## Requirements
- R1: The control value reads back on `ctl_rdata` as follows: bit 7 is window enable, bit 6 is debug-stop, bits 5:3 always read 0, and bits 2:0 are the rate. After reset, the fields take their parameter values, which are all zero by default.
- R2: In special mode, the window bit and the rate field may be rewritten at any time. A rate of 000 leaves the rate unchanged, and a window bit of 0 leaves the window bit unchanged.
- R3: In normal mode, the first control write with bit 5 = 0 locks the window bit and the rate field, even if that write carries zeros. Later writes leave both fields unchanged and do not restart the period.
- R4: A control write with bit 5 = 1 leaves the window bit and the rate field unchanged.
- R5: In normal mode, writing bit 6 as 1 sets debug-stop and writing it as 0 has no effect. In special mode, bit 6 takes the written value.
- R6: The period restarts on either of two control writes: a permitted write of a nonzero rate, or a write that changes debug-stop from 0 to 1.
- R7: A rate n from 1 to 7 gives a period of 2^(BASE_SHIFT+2n) cycles. If that many counted cycles pass after a restart without a kick, `rst_req` goes high for exactly one cycle, in the cycle after the last count. A rate of 0 stops the counter, and service writes are then ignored.
- R8: A 0xAA service write that follows one or more 0x55 writes restarts the period, and no reset request follows.
- R9: Some service writes raise `rst_req` in the next cycle: any value other than 0x55 or 0xAA, or 0xAA with no 0x55 before it.
- R10: With window mode on, a service write made while the count is below three quarters of the period raises `rst_req` in the next cycle. A write made at or above three quarters is accepted.
- R11: While debug-stop is 1 and `debug_halt` is high, the counter holds its value. While debug-stop is 0, `debug_halt` has no effect.
- R12: After a reset request, the counter restarts from zero and the key sequence returns to SEQ_IDLE. The control fields keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | 1 = special mode, where the protection rules are relaxed |
| debug_halt | input | 1 | Debug-halt active |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 1 | 0 = control register, 1 = service register |
| bus_wdata | input | 8 | Write data |
| ctl_rdata | output | 8 | Read value of the control register |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The hardest case to reach is the exact edge of the service window. An accepted and a rejected write differ by a single count, so the stimulus must land on one specific cycle. The bench gets there by taking the restart cycle from a control write or from the reset request just observed. It then drives the key writes at computed offsets from that cycle: one at the last count before three quarters of the period, and one at the first count of the window.

The frozen-counter case takes the same care. The expected timeout moves by exactly the number of halted edges, so the bench raises and drops `debug_halt` on counted cycles.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
    localparam int RATE_W = 3;

    localparam int CTL_WIN_BIT  = 7;
    localparam int CTL_STOP_BIT = 6;
    localparam int CTL_MASK_BIT = 5;

    localparam logic ADDR_CTL = 1'b0;
    localparam logic ADDR_SVC = 1'b1;

    localparam logic [7:0] KEY_ARM  = 8'h55;
    localparam logic [7:0] KEY_FIRE = 8'hAA;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ARMED = 2'd1,
        SEQ_TRIP  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/wdog_ctl_reg.sv
`timescale 1ns/1ps
module wdog_ctl_reg
    import wdog_pkg::*;
#(
    parameter logic              RST_WIN  = 1'b0,
    parameter logic              RST_STOP = 1'b0,
    parameter logic [RATE_W-1:0] RST_RATE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              special_mode,
    input  logic              wr_ctl,
    input  logic [7:0]        wdata,
    output logic              win_en,
    output logic              stop_dbg,
    output logic [RATE_W-1:0] rate,
    output logic              restart,
    output logic              locked,
    output logic [7:0]        rdata
);
    logic              win_q, stop_q, lock_q;
    logic [RATE_W-1:0] rate_q;
    logic              win_d, stop_d, lock_d;
    logic [RATE_W-1:0] rate_d;
    logic              field_ok, rate_nz;
    logic              unused_rsv;

    assign unused_rsv = ^wdata[4:3];

    // Fields may change only when unmasked and either special or unlocked
    assign field_ok = !wdata[CTL_MASK_BIT] && (special_mode || !lock_q);
    assign rate_nz  = (wdata[RATE_W-1:0] != '0);

    always_comb begin
        win_d  = win_q | (field_ok & wdata[CTL_WIN_BIT]);
        rate_d = (field_ok && rate_nz) ? wdata[RATE_W-1:0] : rate_q;
        stop_d = special_mode ? wdata[CTL_STOP_BIT] : (stop_q | wdata[CTL_STOP_BIT]);
        lock_d = lock_q | (!special_mode && !wdata[CTL_MASK_BIT]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q  <= RST_WIN;
            stop_q <= RST_STOP;
            rate_q <= RST_RATE;
            lock_q <= 1'b0;
        end else if (wr_ctl) begin
            win_q  <= win_d;
            stop_q <= stop_d;
            rate_q <= rate_d;
            lock_q <= lock_d;
        end
    end

    assign restart  = wr_ctl && ((field_ok && rate_nz) || (!stop_q && stop_d));
    assign win_en   = win_q;
    assign stop_dbg = stop_q;
    assign rate     = rate_q;
    assign locked   = lock_q;
    assign rdata    = {win_q, stop_q, 3'b000, rate_q};
endmodule

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int BASE_SHIFT = 12,
    parameter int CNT_W      = BASE_SHIFT + 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate,
    input  logic              stop_dbg,
    input  logic              debug_halt,
    input  logic              clear,
    output logic [CNT_W-1:0]  cnt,
    output logic              in_window,
    output logic              expire
);
    logic [CNT_W-1:0] cnt_q, period, last, win_start;
    logic             run;

    always_comb begin
        period    = CNT_W'(1) << (BASE_SHIFT + 2 * int'(rate));
        last      = period - CNT_W'(1);
        win_start = period - (period >> 2);
    end

    assign run       = (rate != '0) && !(stop_dbg && debug_halt);
    assign expire    = run && (cnt_q == last);
    assign in_window = (cnt_q >= win_start);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear || expire)
            cnt_q <= '0;
        else if (run)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/wdog_seq.sv
`timescale 1ns/1ps
module wdog_seq
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       svc_wr,
    input  logic [7:0] wdata,
    input  logic       active,
    input  logic       win_mode,
    input  logic       in_window,
    input  logic       expire,
    output logic       kick,
    output logic       rst_req
);
    seq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        kick    = 1'b0;
        unique case (state_q)
            SEQ_TRIP: state_d = SEQ_IDLE;
            SEQ_IDLE, SEQ_ARMED: begin
                if (svc_wr && active) begin
                    if (win_mode && !in_window)
                        state_d = SEQ_TRIP;
                    else if (wdata == KEY_ARM)
                        state_d = SEQ_ARMED;
                    else if (wdata == KEY_FIRE && state_q == SEQ_ARMED) begin
                        state_d = SEQ_IDLE;
                        kick    = 1'b1;
                    end else
                        state_d = SEQ_TRIP;
                end
                if (expire && !kick)
                    state_d = SEQ_TRIP;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SEQ_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        rst_req = (state_q == SEQ_TRIP);
    end
endmodule

// File: rtl/win_watchdog.sv
`timescale 1ns/1ps
module win_watchdog
    import wdog_pkg::*;
#(
    parameter int                BASE_SHIFT = 12,
    parameter logic              RST_WIN    = 1'b0,
    parameter logic              RST_STOP   = 1'b0,
    parameter logic [RATE_W-1:0] RST_RATE   = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       special_mode,
    input  logic       debug_halt,
    input  logic       bus_wr,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] ctl_rdata,
    output logic       rst_req
);
    localparam int CNT_W = BASE_SHIFT + 15;

    logic              wr_ctl, wr_svc;
    logic              win_en, stop_dbg, ctl_restart, lock_q;
    logic [RATE_W-1:0] rate;
    logic [CNT_W-1:0]  cnt_q;
    logic              win_open, expire, kick, clear;

    assign wr_ctl = bus_wr && (bus_addr == ADDR_CTL);
    assign wr_svc = bus_wr && (bus_addr == ADDR_SVC);
    assign clear  = kick || ctl_restart || rst_req;

    wdog_ctl_reg #(
        .RST_WIN (RST_WIN),
        .RST_STOP(RST_STOP),
        .RST_RATE(RST_RATE)
    ) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .special_mode(special_mode),
        .wr_ctl      (wr_ctl),
        .wdata       (bus_wdata),
        .win_en      (win_en),
        .stop_dbg    (stop_dbg),
        .rate        (rate),
        .restart     (ctl_restart),
        .locked      (lock_q),
        .rdata       (ctl_rdata)
    );

    wdog_counter #(
        .BASE_SHIFT(BASE_SHIFT),
        .CNT_W     (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate      (rate),
        .stop_dbg  (stop_dbg),
        .debug_halt(debug_halt),
        .clear     (clear),
        .cnt       (cnt_q),
        .in_window (win_open),
        .expire    (expire)
    );

    wdog_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .svc_wr   (wr_svc),
        .wdata    (bus_wdata),
        .active   (rate != '0),
        .win_mode (win_en),
        .in_window(win_open),
        .expire   (expire),
        .kick     (kick),
        .rst_req  (rst_req)
    );
endmodule

// File: rtl/win_watchdog_chk.sv
`timescale 1ns/1ps
module win_watchdog_chk #(
    parameter int CNT_W = 27
) (
    input logic             clk,
    input logic             rst_n,
    input logic             special_mode,
    input logic             debug_halt,
    input logic             bus_wr,
    input logic             bus_addr,
    input logic [7:0]       bus_wdata,
    input logic [7:0]       ctl_rdata,
    input logic             rst_req,
    input logic [CNT_W-1:0] cnt,
    input logic             lock,
    input logic             in_win
);
    logic svc_wr, ctl_wr, live;
    assign svc_wr = bus_wr && bus_addr;
    assign ctl_wr = bus_wr && !bus_addr;
    assign live   = (ctl_rdata[2:0] != 3'b000);

    p_locked_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !special_mode && lock) |=> ($stable(ctl_rdata[7]) && $stable(ctl_rdata[2:0])));

    p_rsv_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[5:3] == 3'b000);

    p_stop_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!special_mode && ctl_rdata[6]) |=> ctl_rdata[6]);

    p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !live |-> !rst_req);

    p_bad_key_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_wr && live && !rst_req && bus_wdata != 8'h55 && bus_wdata != 8'hAA) |=> rst_req);

    p_early_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_wr && live && ctl_rdata[7] && !in_win && !rst_req) |=> rst_req);

    p_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[6] && debug_halt && !bus_wr && !rst_req) |=> $stable(cnt));

    p_restart_after_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (cnt == '0 || cnt == CNT_W'(1)));
endmodule

bind win_watchdog win_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .special_mode(special_mode),
    .debug_halt  (debug_halt),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .ctl_rdata   (ctl_rdata),
    .rst_req     (rst_req),
    .cnt         (cnt_q),
    .lock        (lock_q),
    .in_win      (win_open)
);

// File: tb/win_watchdog_bench.sv
`timescale 1ns/1ps
module win_watchdog_bench;
    localparam int BASE = 2;  // rate 1 -> 16 cycles, rate 2 -> 64 cycles

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       special_mode = 1'b0;
    logic       debug_halt = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] ctl_rdata;
    logic       rst_req;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int pulses = 0;
    bit done = 1'b0;

    typedef struct { int at; string tag; } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    win_watchdog #(.BASE_SHIFT(BASE)) u_win_watchdog (
        .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
        .debug_halt(debug_halt), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .ctl_rdata(ctl_rdata), .rst_req(rst_req)
    );

    // Monitor: pops expected reset-request cycles and compares
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (q.size() > 0 && q[0].at < cyc) begin
                checks++; errors++;
                $display("FAIL %s rst_req missing at cycle %0d act=0 exp=1", q[0].tag, q[0].at);
                void'(q.pop_front());
            end
            if (rst_req) begin
                pulses++;
                checks++;
                if (q.size() > 0 && q[0].at == cyc) begin
                    void'(q.pop_front());
                end else begin
                    errors++;
                    $display("FAIL R7 unexpected rst_req at cycle %0d act=1 exp=0", cyc);
                end
            end
        end
    end

    task automatic expect_req(int at, string tag);
        exp_t e;
        e.at = at; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic go_to(int c);
        @(negedge clk);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic bus_now(logic a, logic [7:0] d, output int e);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        e = cyc;
        bus_wr = 1'b0;
    endtask

    task automatic bus_at(logic a, logic [7:0] d, int t);
        go_to(t - 1);
        chk("schedule", cyc, t - 1);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic summary();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8ns * 200000);
        checks++; errors++;
        $display("FAIL watchdog timeout act=running exp=finished");
        summary();
    end

    initial begin
        int e, p0, r, r2, r3, r4, r5, qq, w, v, u, g, h, j, k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 reset value", ctl_rdata, 8'h00);
        p0 = pulses;
        go_to(cyc + 20);
        bus_now(1'b1, 8'h12, e);  // R7: ignored while disabled
        go_to(cyc + 20);
        chk("R7 disabled quiet", pulses, p0);

        // Normal mode protection
        bus_now(1'b0, 8'h21, e);
        chk("R4 masked write", ctl_rdata, 8'h00);
        bus_now(1'b0, 8'h40, e);
        chk("R3 zero write locks / R5 stop set", ctl_rdata, 8'h40);
        bus_now(1'b0, 8'h83, e);
        chk("R3 locked / R5 stop sticky", ctl_rdata, 8'h40);
        go_to(cyc + 40);
        chk("R7 rate zero quiet", pulses, p0);

        // Special mode: timeout and repeat
        @(negedge clk);
        special_mode = 1'b1;
        bus_now(1'b0, 8'h01, e);
        chk("R2 R5 special write", ctl_rdata, 8'h01);
        expect_req(e + 16, "R7");
        expect_req(e + 33, "R12");
        go_to(e + 34);
        chk("R12 fields kept", ctl_rdata, 8'h01);
        r = e + 34;

        // R8 service, R9 bad sequences
        bus_at(1'b1, 8'h55, r + 3);
        bus_at(1'b1, 8'h55, r + 4);
        bus_at(1'b1, 8'hAA, r + 5);
        expect_req(r + 21, "R8");
        r2 = r + 22;
        expect_req(r2 + 2, "R9");
        bus_at(1'b1, 8'hAA, r2 + 2);
        r3 = r2 + 3;
        expect_req(r3 + 2, "R9");
        bus_at(1'b1, 8'h12, r3 + 2);
        r4 = r3 + 3;
        bus_at(1'b1, 8'h55, r4 + 1);
        expect_req(r4 + 2, "R9");
        bus_at(1'b1, 8'h5A, r4 + 2);
        r5 = r4 + 3;
        bus_at(1'b1, 8'h55, r5 + 1);
        bus_at(1'b1, 8'hAA, r5 + 2);
        bus_at(1'b0, 8'h02, r5 + 6);
        chk("R2 rate rewrite", ctl_rdata, 8'h02);
        qq = r5 + 6;
        expect_req(qq + 64, "R7 rate2");
        go_to(qq + 65);

        // R10 window
        bus_now(1'b0, 8'h81, w);
        chk("R2 window on", ctl_rdata, 8'h81);
        expect_req(w + 12, "R10 early");
        bus_at(1'b1, 8'h55, w + 12);
        v = w + 13;
        bus_at(1'b1, 8'h55, v + 13);
        bus_at(1'b1, 8'hAA, v + 14);
        expect_req(v + 15, "R10 after kick");
        bus_at(1'b1, 8'h55, v + 15);
        u = v + 16;
        expect_req(u + 16, "R7 window expiry");
        go_to(u + 17);
        bus_now(1'b0, 8'h01, e);
        chk("R2 window zero ignored", ctl_rdata, 8'h81);

        // R11 freeze
        g = e + 3;
        bus_at(1'b0, 8'h41, g);
        chk("R5 stop set special", ctl_rdata, 8'hC1);
        expect_req(g + 46, "R11 frozen");
        go_to(g + 4);
        debug_halt = 1'b1;
        go_to(g + 34);
        debug_halt = 1'b0;
        go_to(g + 47);
        bus_now(1'b0, 8'h01, h);
        debug_halt = 1'b1;
        chk("R5 stop clear special", ctl_rdata, 8'h81);
        expect_req(h + 16, "R11 running");
        go_to(h + 17);
        debug_halt = 1'b0;

        // R6 stop rise restart
        j = h + 25;
        expect_req(j + 16, "R6");
        bus_at(1'b0, 8'h60, j);
        chk("R6 masked stop write", ctl_rdata, 8'hC1);
        go_to(j + 17);

        // R3 second reset, normal mode write-once with nonzero
        rst_n = 1'b0;
        special_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset again", ctl_rdata, 8'h00);
        bus_now(1'b0, 8'h81, k);
        chk("R3 first write", ctl_rdata, 8'h81);
        expect_req(k + 16, "R3 no restart");
        bus_at(1'b0, 8'h03, k + 2);
        chk("R3 second write ignored", ctl_rdata, 8'h81);
        go_to(k + 20);
        chk("R7 all pulses seen", q.size(), 0);
        summary();
    end
endmodule